// File: doc/BRIEF.md
# Parallel ADC Conversion-and-Read Sequencer

This block drives a 12-bit converter that has a parallel data bus. The converter has four control lines: an active-low convert strobe, an active-low busy line, and active-low chip-select and read strobes. A conversion starts on a single-cycle request pulse. It can also start from a free-running rate when automatic mode is enabled. The sequencer first drives the convert strobe low for a fixed number of clock cycles. It then waits for busy to fall, which marks the start of the conversion, and for busy to rise again, which marks the end. Next it drops chip-select and read together for a fixed read window. It latches the data bus on the last edge of that window and presents the word with a one-cycle valid pulse.

Every analog timing rule of the converter is expressed in system clock cycles and set by a parameter:
- the convert pulse width;
- how long busy may take to fall;
- the longest conversion;
- the read pulse width, which covers the data access time;
- the acquisition time between busy rising and the next convert;
- the minimum spacing between convert strobes.

A request that comes in too early is remembered and started at the first permitted edge. If busy never falls, or never rises again, the sequencer flags a one-cycle fault and returns to idle without reading.

The busy input passes through a synchronizer of `SYNC_STAGES` flops before the controller uses it.

Top module: `adc_conv_seq`

## Requirements
- R1: While and right after reset, `conv_n_o`, `cs_n_o` and `rd_n_o` are 1, and `smp_valid_o` and `fault_o` are 0.
- R2: A request on `trig_i` (one cycle, high = request) drives `conv_n_o` low from the next clock edge. This holds when the sequencer is idle and both the interval and the acquisition limits are already met. `conv_n_o` then stays low for exactly `CONV_PULSE` cycles.
- R3: `cs_n_o` and `rd_n_o` fall together, and only after `busy_n_i` has gone low and then returned high (1 = not busy). They stay low for exactly `READ_LEN` cycles. `cs_n_o` is never high while `rd_n_o` is low, and it is high whenever `conv_n_o` falls.
- R4: `smp_data_o` holds the value of `adc_data_i` at the clock edge that ends the read window. `smp_valid_o` is high for exactly one cycle, starting at the same edge that raises `rd_n_o`.
- R5: Two successive falling edges of `conv_n_o` are at least `SAMPLE_MIN` cycles apart.
- R6: A falling edge of `conv_n_o` comes at least `ACQ_MIN` cycles after `busy_n_i` last returned high.
- R7: A request that arrives before the limits allow a start is held, not dropped. When the acquisition limit is not the binding one, the conversion starts exactly `SAMPLE_MIN` cycles after the previous convert fall. Several requests made while one is held produce a single conversion.
- R8: While `auto_en_i` is 1, conversions start every `PERIOD` cycles, provided each one finishes in time.
- R9: If busy has not been seen low within `FALL_TMO` cycles of the end of the convert pulse, `fault_o` pulses high for one cycle. The pulse rises exactly `CONV_PULSE + FALL_TMO` cycles after the convert fall. No read follows, and the sequencer returns to idle.
- R10: If busy stays low for `CONV_TMO` cycles, `fault_o` pulses for one cycle and no read follows. The next request after busy recovers then completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Single-cycle conversion request |
| auto_en_i | input | 1 | Free-running conversion at `PERIOD` cycles |
| busy_n_i | input | 1 | Converter busy, low while converting |
| adc_data_i | input | DATA_W | Converter parallel data bus |
| conv_n_o | output | 1 | Convert strobe, active low |
| cs_n_o | output | 1 | Chip-select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| smp_valid_o | output | 1 | One-cycle sample valid |
| smp_data_o | output | DATA_W | Captured sample |
| fault_o | output | 1 | One-cycle busy-handshake timeout |

## Verification
The bench targets the corner cases below; each note says how a faulty design would show up.

- **Held requests.** A request made during a conversion must start exactly at the interval limit. A design that dropped held requests would lose the sample, and one that counted from the wrong edge would shift the start. Several requests during one conversion must collapse into a single start; a design that queued them would produce extra strobes.
- **Read timing.** The converter stub delays valid data by two read cycles, so a design that latched early would return the inverted garbage word. The stub also varies its busy latency and conversion length, and a design that read before busy returned high is caught at the read edge.
- **Timeouts.** Both time-outs are forced. A missing or mistimed fault, or a read after a fault, is reported.
- **Automatic mode.** Its period is measured edge to edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PULSE,
    SQ_WFALL,
    SQ_WRISE,
    SQ_READ
  } sq_state_e;
endpackage

// File: rtl/adc_seq_sync.sv
module adc_seq_sync #(
  parameter int STAGES = 2,
  parameter bit INIT   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adc_seq_pacer.sv
module adc_seq_pacer #(
  parameter int SAMPLE_MIN = 67,
  parameter int ACQ_MIN    = 13,
  parameter int PERIOD     = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  input  logic auto_en_i,
  input  logic start_go_i,
  input  logic busy_rise_i,
  output logic start_req_o
);
  localparam int SPAN_TOP = ((PERIOD > SAMPLE_MIN) ? PERIOD : SAMPLE_MIN) - 1;
  localparam int SPAN_W   = $clog2(SPAN_TOP + 2);
  localparam int ACQ_TOP  = (ACQ_MIN > 0) ? ACQ_MIN - 1 : 0;
  localparam int ACQ_W    = $clog2(ACQ_TOP + 2);
  localparam logic [SPAN_W-1:0] SPAN_LIM = SPAN_W'(SPAN_TOP);
  localparam logic [SPAN_W-1:0] IVL_LIM  = SPAN_W'((SAMPLE_MIN > 0) ? SAMPLE_MIN - 1 : 0);
  localparam logic [SPAN_W-1:0] AUTO_LIM = SPAN_W'((PERIOD > 0) ? PERIOD - 1 : 0);
  localparam logic [ACQ_W-1:0]  ACQ_LIM  = ACQ_W'(ACQ_TOP);

  logic [SPAN_W-1:0] span_q;
  logic [ACQ_W-1:0]  acq_q;
  logic              pend_q;
  logic              ivl_ok, acq_ok, auto_due;

  // cycles since the last convert start, saturating
  always_ff @(posedge clk) begin
    if (rst)                    span_q <= SPAN_LIM;
    else if (start_go_i)        span_q <= '0;
    else if (span_q != SPAN_LIM) span_q <= span_q + 1'b1;
  end

  // cycles since busy was seen returning high, saturating
  always_ff @(posedge clk) begin
    if (rst)                   acq_q <= ACQ_LIM;
    else if (busy_rise_i)      acq_q <= '0;
    else if (acq_q != ACQ_LIM) acq_q <= acq_q + 1'b1;
  end

  // one held request; repeats coalesce
  always_ff @(posedge clk) begin
    if (rst) pend_q <= 1'b0;
    else     pend_q <= (pend_q | trig_i) & ~start_go_i;
  end

  assign ivl_ok      = (span_q >= IVL_LIM);
  assign acq_ok      = (acq_q == ACQ_LIM);
  assign auto_due    = auto_en_i && (span_q >= AUTO_LIM);
  assign start_req_o = (pend_q | trig_i | auto_due) & ivl_ok & acq_ok;

  // R5: a start is only taken once the sampling interval has run out
  a_r5_interval_met: assert property (@(posedge clk) disable iff (rst)
    start_go_i |-> (span_q >= IVL_LIM));
  // R6: a start is only taken once the acquisition time has run out
  a_r6_acq_met: assert property (@(posedge clk) disable iff (rst)
    start_go_i |-> (acq_q == ACQ_LIM));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int CONV_PULSE = 3,
  parameter int FALL_TMO   = 8,
  parameter int CONV_TMO   = 60,
  parameter int READ_LEN   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req_i,
  input  logic busy_hi_i,
  output logic start_go_o,
  output logic busy_rise_o,
  output logic cap_en_o,
  output logic conv_n_o,
  output logic cs_n_o,
  output logic rd_n_o,
  output logic fault_o
);
  localparam int M1    = (CONV_PULSE > FALL_TMO) ? CONV_PULSE : FALL_TMO;
  localparam int M2    = (CONV_TMO > READ_LEN) ? CONV_TMO : READ_LEN;
  localparam int PH_TOP = ((M1 > M2) ? M1 : M2) - 1;
  localparam int PH_W  = $clog2(PH_TOP + 2);
  localparam logic [PH_W-1:0] PULSE_LAST = PH_W'(CONV_PULSE - 1);
  localparam logic [PH_W-1:0] FALL_LAST  = PH_W'(FALL_TMO - 1);
  localparam logic [PH_W-1:0] RISE_LAST  = PH_W'(CONV_TMO - 1);
  localparam logic [PH_W-1:0] READ_LAST  = PH_W'(READ_LEN - 1);

  sq_state_e       state_q;
  logic [PH_W-1:0] ph_q;
  logic            conv_n_q, cs_n_q, rd_n_q, fault_q;

  assign start_go_o  = (state_q == SQ_IDLE) && start_req_i;
  assign busy_rise_o = (state_q == SQ_WRISE) && busy_hi_i;
  assign cap_en_o    = (state_q == SQ_READ) && (ph_q == READ_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SQ_IDLE;
      ph_q     <= '0;
      conv_n_q <= 1'b1;
      cs_n_q   <= 1'b1;
      rd_n_q   <= 1'b1;
      fault_q  <= 1'b0;
    end else begin
      fault_q <= 1'b0;
      case (state_q)
        SQ_IDLE: begin
          if (start_go_o) begin
            state_q  <= SQ_PULSE;
            ph_q     <= '0;
            conv_n_q <= 1'b0;
          end
        end
        SQ_PULSE: begin
          if (ph_q == PULSE_LAST) begin
            conv_n_q <= 1'b1;
            state_q  <= SQ_WFALL;
            ph_q     <= '0;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        SQ_WFALL: begin
          if (!busy_hi_i) begin
            state_q <= SQ_WRISE;
            ph_q    <= '0;
          end else if (ph_q == FALL_LAST) begin
            fault_q <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        SQ_WRISE: begin
          if (busy_hi_i) begin
            state_q <= SQ_READ;
            ph_q    <= '0;
            cs_n_q  <= 1'b0;
            rd_n_q  <= 1'b0;
          end else if (ph_q == RISE_LAST) begin
            fault_q <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        SQ_READ: begin
          if (ph_q == READ_LAST) begin
            cs_n_q  <= 1'b1;
            rd_n_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_n_o = conv_n_q;
  assign cs_n_o   = cs_n_q;
  assign rd_n_o   = rd_n_q;
  assign fault_o  = fault_q;

  // R3: the read strobe only falls after synchronized busy was high
  a_r3_read_after_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n_q) |-> $past(busy_hi_i));
  // R3: chip-select covers the whole read pulse
  a_r3_cs_covers_rd: assert property (@(posedge clk) disable iff (rst)
    !rd_n_q |-> !cs_n_q);
  // R3: chip-select is released whenever a convert strobe begins
  a_r3_cs_high_at_conv: assert property (@(posedge clk) disable iff (rst)
    $fell(conv_n_q) |-> cs_n_q);
  // R9, R10: a fault leaves every strobe inactive
  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> (conv_n_q && cs_n_q && rd_n_q));
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= cap_en_i;
  end

  always_ff @(posedge clk) begin
    if (rst)           data_q <= '0;
    else if (cap_en_i) data_q <= data_i;
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;

  // R4: the valid strobe lasts a single cycle
  a_r4_valid_single: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int DATA_W      = 12,
  parameter int CONV_PULSE  = 3,
  parameter int FALL_TMO    = 8,
  parameter int CONV_TMO    = 60,
  parameter int READ_LEN    = 4,
  parameter int ACQ_MIN     = 13,
  parameter int SAMPLE_MIN  = 67,
  parameter int PERIOD      = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_i,
  input  logic              auto_en_i,
  input  logic              busy_n_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic              conv_n_o,
  output logic              cs_n_o,
  output logic              rd_n_o,
  output logic              smp_valid_o,
  output logic [DATA_W-1:0] smp_data_o,
  output logic              fault_o
);
  logic busy_hi, start_req, start_go, busy_rise, cap_en;

  adc_seq_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(busy_n_i), .q(busy_hi)
  );

  adc_seq_pacer #(.SAMPLE_MIN(SAMPLE_MIN), .ACQ_MIN(ACQ_MIN), .PERIOD(PERIOD)) u_pacer (
    .clk(clk), .rst(rst), .trig_i(trig_i), .auto_en_i(auto_en_i),
    .start_go_i(start_go), .busy_rise_i(busy_rise), .start_req_o(start_req)
  );

  adc_seq_fsm #(.CONV_PULSE(CONV_PULSE), .FALL_TMO(FALL_TMO),
                .CONV_TMO(CONV_TMO), .READ_LEN(READ_LEN)) u_fsm (
    .clk(clk), .rst(rst), .start_req_i(start_req), .busy_hi_i(busy_hi),
    .start_go_o(start_go), .busy_rise_o(busy_rise), .cap_en_o(cap_en),
    .conv_n_o(conv_n_o), .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .fault_o(fault_o)
  );

  adc_seq_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst(rst), .cap_en_i(cap_en), .data_i(adc_data_i),
    .valid_o(smp_valid_o), .data_o(smp_data_o)
  );
endmodule

// File: tb/tb_adc_conv_seq.sv
`timescale 1ns/1ps
module tb_adc_conv_seq;
  localparam int DW = 12, CP = 3, FT = 8, CT = 60, RL = 4, AQ = 13, SM = 67, PD = 80;

  logic clk = 1'b0, rst = 1'b1, trig = 1'b0, auto_en = 1'b0, busy_n = 1'b1;
  logic [DW-1:0] adc_data = '0;
  logic conv_n, cs_n, rd_n, valid, fault;
  logic [DW-1:0] smp;

  adc_conv_seq #(.DATA_W(DW), .CONV_PULSE(CP), .FALL_TMO(FT), .CONV_TMO(CT),
                 .READ_LEN(RL), .ACQ_MIN(AQ), .SAMPLE_MIN(SM), .PERIOD(PD),
                 .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .trig_i(trig), .auto_en_i(auto_en), .busy_n_i(busy_n),
    .adc_data_i(adc_data), .conv_n_o(conv_n), .cs_n_o(cs_n), .rd_n_o(rd_n),
    .smp_valid_o(valid), .smp_data_o(smp), .fault_o(fault)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // stub controls
  int stub_lat = 1, stub_conv = 20;
  bit stub_nofall = 0, stub_stuck = 0;
  int expect_gap = 0;
  string gap_req = "R7";
  // monitor state
  int cyc = 0, n_fall = 0, n_valid = 0, n_fault = 0, n_rd = 0;
  int last_fall = 0, conv_start = 0, rd_start = 0, rise_cyc = 0, fault_cyc = 0;
  bit have_fall = 0, rise_seen = 0;
  int sph = 0, scnt = 0, rdlow = 0;
  logic [DW-1:0] cur_word = '0;
  logic conv_prev = 1, rd_prev = 1, valid_prev = 0, fault_prev = 0;

  function automatic int exp_fault_delay();
    return CP + FT;
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      busy_n = 1'b1; sph = 0; conv_prev = 1; rd_prev = 1; valid_prev = 0; fault_prev = 0;
    end else begin
      cyc++;
      if (!conv_n && conv_prev) begin
        n_fall++;
        if (have_fall) begin
          chk((cyc - last_fall) >= SM, "R5 convert spacing", cyc - last_fall, SM);
          if (expect_gap != 0) chk((cyc - last_fall) == expect_gap, gap_req, cyc - last_fall, expect_gap);
        end
        if (rise_seen) chk((cyc - rise_cyc) >= AQ, "R6 acquisition", cyc - rise_cyc, AQ);
        chk(cs_n == 1'b1, "R3 cs high at convert", cs_n, 1);
        rise_seen = 0; have_fall = 1; last_fall = cyc; conv_start = cyc;
        cur_word = DW'($urandom);
        if (!stub_nofall) begin sph = 1; scnt = stub_lat; end
      end
      if (conv_n && !conv_prev) chk((cyc - conv_start) == CP, "R2 pulse width", cyc - conv_start, CP);
      if (sph == 1) begin
        if (scnt == 0) begin busy_n = 1'b0; sph = 2; scnt = stub_conv; end
        else scnt--;
      end else if (sph == 2 && !stub_stuck) begin
        if (scnt == 0) begin busy_n = 1'b1; sph = 0; rise_cyc = cyc; rise_seen = 1; end
        else scnt--;
      end
      if (!rd_n && rd_prev) begin
        n_rd++;
        chk(busy_n == 1'b1 && sph == 0, "R3 read after busy high", busy_n, 1);
        chk(cs_n == 1'b0, "R3 cs with read", cs_n, 0);
        rd_start = cyc;
      end
      if (rd_n && !rd_prev) chk((cyc - rd_start) == RL, "R3 read width", cyc - rd_start, RL);
      if (!rd_n && cs_n) chk(0, "R3 cs dropped during read", cs_n, 0);
      rdlow = rd_n ? 0 : rdlow + 1;
      adc_data = (rdlow >= 2) ? cur_word : ~cur_word;
      if (valid) begin
        n_valid++;
        chk(smp == cur_word, "R4 captured word", smp, cur_word);
        chk(rd_n && !rd_prev, "R4 valid with read release", rd_n, 1);
        if (valid_prev) chk(0, "R4 valid single cycle", 1, 0);
      end
      if (fault) begin
        n_fault++; fault_cyc = cyc;
        if (fault_prev) chk(0, "R9 fault single cycle", 1, 0);
      end
      conv_prev = conv_n; rd_prev = rd_n; valid_prev = valid; fault_prev = fault;
    end
  end

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    int f0, v0, r0, k0, seed;
    seed = $urandom(32'd24680);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(conv_n && cs_n && rd_n, "R1 strobes idle after reset", {conv_n, cs_n, rd_n}, 7);
    chk(!valid && !fault, "R1 valid and fault low", {valid, fault}, 0);
    idle(5);

    // R2: immediate start from ready idle
    f0 = n_fall;
    pulse_trig(); #1;
    chk(conv_n == 1'b0 && n_fall == f0 + 1 && last_fall == cyc, "R2 start on next edge", n_fall - f0, 1);
    idle(150);
    chk(n_valid == 1, "R4 first sample delivered", n_valid, 1);

    // R7: held request starts exactly at the interval limit
    stub_conv = 20; stub_lat = 2;
    f0 = n_fall;
    pulse_trig();
    idle(10);
    gap_req = "R7 held request gap";
    expect_gap = SM;
    pulse_trig();
    idle(120);
    expect_gap = 0;
    chk(n_fall == f0 + 2, "R7 held request served", n_fall - f0, 2);

    // R7: several held requests coalesce
    f0 = n_fall;
    pulse_trig();
    idle(5); pulse_trig(); idle(5); pulse_trig(); idle(5); pulse_trig();
    idle(250);
    chk(n_fall == f0 + 2, "R7 requests coalesce", n_fall - f0, 2);

    // R8: automatic mode period
    f0 = n_fall;
    auto_en = 1'b1;
    while (n_fall == f0) @(posedge clk);
    idle(3);
    gap_req = "R8 auto period";
    expect_gap = PD;
    while (n_fall < f0 + 5) @(posedge clk);
    idle(3);
    expect_gap = 0;
    auto_en = 1'b0;
    idle(200);
    chk(n_fall >= f0 + 5, "R8 auto conversions", n_fall - f0, 5);

    // R9: busy never falls
    stub_nofall = 1;
    f0 = n_fall; v0 = n_valid; r0 = n_rd; k0 = n_fault;
    pulse_trig();
    idle(60);
    chk(n_fault == k0 + 1, "R9 fault raised", n_fault - k0, 1);
    chk((fault_cyc - last_fall) == exp_fault_delay(), "R9 fault timing", fault_cyc - last_fall, exp_fault_delay());
    chk(n_rd == r0 && n_valid == v0, "R9 no read after fault", n_rd - r0, 0);
    stub_nofall = 0;
    idle(60);

    // R10: busy stuck low
    stub_stuck = 1;
    k0 = n_fault; r0 = n_rd; v0 = n_valid;
    pulse_trig();
    idle(120);
    chk(n_fault == k0 + 1, "R10 fault raised", n_fault - k0, 1);
    chk((fault_cyc - last_fall) >= CT, "R10 fault after limit", fault_cyc - last_fall, CT);
    chk(n_rd == r0 && n_valid == v0, "R10 no read after fault", n_rd - r0, 0);
    stub_stuck = 0;
    idle(150);
    v0 = n_valid;
    pulse_trig();
    idle(150);
    chk(n_valid == v0 + 1, "R10 recovery conversion", n_valid - v0, 1);

    // random traffic
    for (int i = 0; i < 40; i++) begin
      stub_lat = int'($urandom_range(0, 4));
      stub_conv = int'($urandom_range(10, 49));
      idle(int'($urandom_range(0, 150)));
      pulse_trig();
    end
    idle(300);
    chk(n_valid == n_fall - n_fault, "R4 one sample per good conversion", n_valid, n_fall - n_fault);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule